// File: doc/BRIEF.md
# Host I/O Write Snoop Capture Queue

This block sits beside a host I/O decoder and watches every decoded host write cycle, presented as a one-cycle valid strobe with a 16-bit port address and an 8-bit data byte. When a write lands on one of two programmable port addresses, its data byte is stored in a 128-entry first-in first-out queue together with a tag that records which address it matched. A management processor drains the queue through a small byte-wide register window and receives a level interrupt when captured data is waiting.

A double-word mode lets the block record four-byte progress codes: it then follows only the first address and the three ports above it, and it marks the byte that completes each group of four. A second monitor raises a sticky flag whenever the host reset line changes level. That flag can also drive the interrupt, and software clears it by writing a one.

Top module: `host_snoop_fifo`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Address 1 is read and written as a low byte at offset 0x10 and a high byte at offset 0x12. Address 2 uses offset 0x02 for the low byte and 0x04 for the high byte. Each reads back the value last written.
- R3: In normal mode (enable bit 2 clear), a host write is captured only when its full 16-bit address equals address 1 with enable bit 7 set, or equals address 2 with enable bit 6 set. All other host writes leave the queue unchanged.
- R4: In the status register at offset 0x08, bit 7 is one when the queue holds data. Bit 0 gives the tag of the oldest entry: 0 for an address 1 match and 1 for an address 2 match. When both addresses match, address 1 wins.
- R5: A read of the data register at offset 0x0A returns the oldest byte and removes it. Up to 128 entries leave in the order they arrived.
- R6: A capture that arrives while 128 entries are held is discarded and sets status bit 5. That bit reads zero again once the queue is empty.
- R7: Writing a one to status bit 5 clears the overflow indication while data remains queued.
- R8: A read of the data register while the queue is empty returns zero and leaves the queue and the status unchanged.
- R9: With enable bit 2 set, writes to address 1 through address 1 plus 3 are captured and address 2 is ignored. The tag is 1 only on the byte from address 1 plus 3 and 0 on the other three.
- R10: Bit 6 of the miscellaneous status register at offset 0x0C becomes one on any change of `host_rst_lvl`. Writing one to that bit clears it, and writing zero has no effect.
- R11: `irq` is high while data is queued with enable bit 3 set, or while the reset-change flag is set with enable bit 4 set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_vld | input | 1 | Decoded host I/O write strobe, one cycle per write |
| host_wr_addr | input | 16 | Host I/O port address |
| host_wr_data | input | 8 | Host I/O write data |
| host_rst_lvl | input | 1 | Host reset level, synchronous to clk |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at offset 0x0A) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Active-high level interrupt |

## Verification
The assertions take three things for granted: `host_rst_lvl` is already synchronous to `clk`, each register strobe lasts one cycle, and the reset line is low while the device comes out of reset. The stimulus keeps to these limits. It changes every input at the falling edge, raises strobes for exactly one cycle, and holds the host reset level at zero through reset. The sweeps fill the queue completely with an arithmetic data pattern whose tags alternate, push one capture past full, and drain the queue while comparing each byte and tag against values the bench computes.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int RAW = 5;

  localparam logic [RAW-1:0] OFS_A2_LO = 5'h02;
  localparam logic [RAW-1:0] OFS_A2_HI = 5'h04;
  localparam logic [RAW-1:0] OFS_CTRL  = 5'h06;
  localparam logic [RAW-1:0] OFS_QSTAT = 5'h08;
  localparam logic [RAW-1:0] OFS_QDATA = 5'h0A;
  localparam logic [RAW-1:0] OFS_MSTAT = 5'h0C;
  localparam logic [RAW-1:0] OFS_A1_LO = 5'h10;
  localparam logic [RAW-1:0] OFS_A1_HI = 5'h12;

  localparam int CB_A1_ON  = 7;
  localparam int CB_A2_ON  = 6;
  localparam int CB_RSTIE  = 4;
  localparam int CB_RDYIE  = 3;
  localparam int CB_DWMODE = 2;

  localparam int SB_VALID = 7;
  localparam int SB_OVF   = 5;
  localparam int MB_RSTCH = 6;

  typedef struct packed {
    logic       tag;
    logic [7:0] data;
  } snoop_entry_t;
endpackage

// File: rtl/snoop_match.sv
module snoop_match #(
  parameter int AW = 16,
  parameter int DW_SPAN = 4
) (
  input  logic          vld,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] port1,
  input  logic [AW-1:0] port2,
  input  logic          en1,
  input  logic          en2,
  input  logic          dw_mode,
  output logic          hit,
  output logic          tag
);
  logic [AW-1:0] delta;
  logic          hit1;
  logic          hit2;

  always_comb begin
    delta = addr - port1;
    hit1  = vld && en1 && (addr == port1);
    hit2  = vld && en2 && (addr == port2);
    if (dw_mode) begin
      hit = vld && (delta < AW'(DW_SPAN));
      tag = (delta == AW'(DW_SPAN - 1));
    end else begin
      hit = hit1 || hit2;
      tag = !hit1;
    end
  end
endmodule

// File: rtl/snoop_fifo.sv
module snoop_fifo #(
  parameter int DEPTH = 128,
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign rdata = mem[rd_ptr_q];

  always_comb begin
    push_ok  = push && !full;
    pop_ok   = pop && !empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end

  // R5: occupancy never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R6: a push into a full queue without a pop leaves it full
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/snoop_rstmon.sv
module snoop_rstmon (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic flag_d;

  always_comb begin
    flag_d = (lvl != prev_q) || (flag && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= lvl;
      flag   <= flag_d;
    end
  end

  // R10: a level change always leaves the flag set on the next cycle
  p_change_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != prev_q) |=> flag);
endmodule

// File: rtl/host_snoop_fifo.sv
module host_snoop_fifo
  import snoop_pkg::*;
#(
  parameter int AW = 16,
  parameter int DEPTH = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr_vld,
  input  logic [15:0]    host_wr_addr,
  input  logic [7:0]     host_wr_data,
  input  logic           host_rst_lvl,
  input  logic [4:0]     reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           irq
);
  localparam int EW = $bits(snoop_entry_t);

  logic [AW-1:0] port1_q, port1_d;
  logic [AW-1:0] port2_q, port2_d;
  logic [7:0]    ctrl_q, ctrl_d;
  logic          ovf_q, ovf_d;
  logic          hit, tag;
  logic          q_empty, q_full, pop;
  logic          ovf_vis;
  logic          rst_flag, rst_clr;
  snoop_entry_t  head, new_ent;

  snoop_match #(.AW(AW), .DW_SPAN(4)) match_i (
    .vld     (host_wr_vld),
    .addr    (host_wr_addr),
    .port1   (port1_q),
    .port2   (port2_q),
    .en1     (ctrl_q[CB_A1_ON]),
    .en2     (ctrl_q[CB_A2_ON]),
    .dw_mode (ctrl_q[CB_DWMODE]),
    .hit     (hit),
    .tag     (tag)
  );

  assign new_ent = '{tag: tag, data: host_wr_data};
  assign pop     = reg_rd && (reg_addr == OFS_QDATA);

  snoop_fifo #(.DEPTH(DEPTH), .W(EW)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (hit),
    .pop   (pop),
    .wdata (new_ent),
    .rdata (head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign rst_clr = reg_wr && (reg_addr == OFS_MSTAT) && reg_wdata[MB_RSTCH];

  snoop_rstmon rstmon_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (host_rst_lvl),
    .clr   (rst_clr),
    .flag  (rst_flag)
  );

  always_comb begin
    port1_d = port1_q;
    port2_d = port2_q;
    ctrl_d  = ctrl_q;
    ovf_d   = ovf_q;
    if (reg_wr) begin
      case (reg_addr)
        OFS_A1_LO: port1_d[7:0]    = reg_wdata;
        OFS_A1_HI: port1_d[AW-1:8] = reg_wdata[AW-9:0];
        OFS_A2_LO: port2_d[7:0]    = reg_wdata;
        OFS_A2_HI: port2_d[AW-1:8] = reg_wdata[AW-9:0];
        OFS_CTRL:  ctrl_d          = reg_wdata;
        default: ;
      endcase
    end
    if (hit && q_full) ovf_d = 1'b1;
    else if (q_empty || (reg_wr && reg_addr == OFS_QSTAT && reg_wdata[SB_OVF])) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port1_q <= '0;
      port2_q <= '0;
      ctrl_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      port1_q <= port1_d;
      port2_q <= port2_d;
      ctrl_q  <= ctrl_d;
      ovf_q   <= ovf_d;
    end
  end

  assign ovf_vis = ovf_q && !q_empty;

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      OFS_A1_LO: reg_rdata = port1_q[7:0];
      OFS_A1_HI: reg_rdata = port1_q[AW-1:8];
      OFS_A2_LO: reg_rdata = port2_q[7:0];
      OFS_A2_HI: reg_rdata = port2_q[AW-1:8];
      OFS_CTRL:  reg_rdata = ctrl_q;
      OFS_QSTAT: begin
        reg_rdata[SB_VALID] = !q_empty;
        reg_rdata[SB_OVF]   = ovf_vis;
        reg_rdata[0]        = !q_empty && head.tag;
      end
      OFS_QDATA: reg_rdata = q_empty ? 8'h00 : head.data;
      OFS_MSTAT: reg_rdata[MB_RSTCH] = rst_flag;
      default: ;
    endcase
  end

  assign irq = (!q_empty && ctrl_q[CB_RDYIE]) || (rst_flag && ctrl_q[CB_RSTIE]);

  // R6: a capture refused by a full queue shows as overflow next cycle
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && q_full && !pop) |=> ovf_vis);

  // R8: popping an empty queue with no capture keeps it empty
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && q_empty && !hit) |=> q_empty);
endmodule

// File: tb/host_snoop_fifo_tb_top.sv
`timescale 1ns/1ps
module host_snoop_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_vld;
  logic [15:0] host_wr_addr;
  logic [7:0]  host_wr_data;
  logic        host_rst_lvl;
  logic [4:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  host_snoop_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_vld(host_wr_vld), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_rst_lvl(host_rst_lvl), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rwr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rrd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic hwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr_addr = a; host_wr_data = d; host_wr_vld = 1'b1;
    @(negedge clk);
    host_wr_vld = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; host_wr_vld = 0; host_wr_addr = 0; host_wr_data = 0;
    host_rst_lvl = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rrd(5'h06, v); check("R1 ctrl", v, 0);
    rrd(5'h08, v); check("R1 qstat", v, 0);
    rrd(5'h0C, v); check("R1 mstat", v, 0);
    rrd(5'h10, v); check("R1 a1lo", v, 0);
    check("R1 irq", irq, 0);

    // R2: address programming
    rwr(5'h10, 8'h80); rwr(5'h12, 8'h00);
    rwr(5'h02, 8'h34); rwr(5'h04, 8'h12);
    rrd(5'h10, v); check("R2 a1lo", v, 8'h80);
    rrd(5'h12, v); check("R2 a1hi", v, 8'h00);
    rrd(5'h02, v); check("R2 a2lo", v, 8'h34);
    rrd(5'h04, v); check("R2 a2hi", v, 8'h12);

    // R3: disabled addresses ignored
    hwr(16'h0080, 8'h55);
    rrd(5'h08, v); check("R3 disabled", v, 0);

    // R3/R4: normal mode matching and tags
    rwr(5'h06, 8'hC0);
    hwr(16'h0080, 8'h11);
    hwr(16'h0081, 8'h99);
    hwr(16'h1234, 8'h22);
    hwr(16'h1235, 8'h98);
    hwr(16'h0034, 8'h97);
    check("R11 rdy disabled", irq, 0);
    rrd(5'h08, v); check("R4 stat addr1", v, 8'h80);
    rrd(5'h0A, v); check("R3 data1", v, 8'h11);
    rrd(5'h08, v); check("R4 stat addr2", v, 8'h81);
    rrd(5'h0A, v); check("R3 data2", v, 8'h22);
    rrd(5'h08, v); check("R3 others ignored", v, 0);

    // R8: empty read
    rrd(5'h0A, v); check("R8 empty data", v, 0);
    rrd(5'h08, v); check("R8 status kept", v, 0);
    hwr(16'h0080, 8'h66);
    rrd(5'h0A, v); check("R8 queue intact", v, 8'h66);

    // R11: ready interrupt
    rwr(5'h06, 8'hC8);
    check("R11 idle", irq, 0);
    hwr(16'h1234, 8'h44);
    check("R11 ready", irq, 1);
    rrd(5'h0A, v); check("R11 pop data", v, 8'h44);
    check("R11 drained", irq, 0);

    // R5/R6: fill, overflow, drain
    for (int i = 0; i < 128; i++) hwr(i[0] ? 16'h1234 : 16'h0080, pat(i));
    hwr(16'h0080, 8'hEE);
    rrd(5'h08, v); check("R6 full ovf", v, 8'hA0);
    for (int i = 0; i < 128; i++) begin
      rrd(5'h08, v); check("R4 tag sweep", v[0], i & 1);
      rrd(5'h0A, v); check("R5 order", v, pat(i));
    end
    rrd(5'h08, v); check("R6 ovf gone when empty", v, 0);

    // R7: overflow cleared by write one
    for (int i = 0; i < 129; i++) hwr(16'h0080, pat(i + 3));
    rwr(5'h08, 8'h20);
    rrd(5'h08, v); check("R7 ovf cleared", v, 8'h80);
    for (int i = 0; i < 128; i++) begin
      rrd(5'h0A, v);
      if (i == 127) check("R7 last entry", v, pat(130));
    end
    rrd(5'h08, v); check("R7 empty", v, 0);

    // R9: double-word mode
    rwr(5'h06, 8'h04);
    hwr(16'h0080, 8'hA0);
    hwr(16'h0081, 8'hA1);
    hwr(16'h1234, 8'hBB);
    hwr(16'h0082, 8'hA2);
    hwr(16'h0083, 8'hA3);
    hwr(16'h0084, 8'hA4);
    hwr(16'h007F, 8'hA5);
    for (int i = 0; i < 4; i++) begin
      rrd(5'h08, v); check("R9 dw status", v, (i == 3) ? 8'h81 : 8'h80);
      rrd(5'h0A, v); check("R9 dw data", v, 8'hA0 + i);
    end
    rrd(5'h08, v); check("R9 a2 ignored", v, 0);

    // R10/R11: host reset change flag
    rwr(5'h06, 8'h10);
    @(negedge clk); host_rst_lvl = 1'b1;
    @(negedge clk); @(negedge clk);
    rrd(5'h0C, v); check("R10 flag set", v, 8'h40);
    check("R11 rst irq", irq, 1);
    rwr(5'h0C, 8'h00);
    rrd(5'h0C, v); check("R10 write zero no effect", v, 8'h40);
    rwr(5'h0C, 8'h40);
    rrd(5'h0C, v); check("R10 cleared", v, 0);
    check("R11 rst irq low", irq, 0);
    @(negedge clk); host_rst_lvl = 1'b0;
    @(negedge clk); @(negedge clk);
    rrd(5'h0C, v); check("R10 falling change", v, 8'h40);
    rwr(5'h06, 8'h00);
    check("R11 masked", irq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule